// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits beside a small cache and serves its misses. A miss that no stream buffer can serve is forwarded to memory as a demand read. A stream buffer is then reloaded with the blocks that follow the missing one. These blocks are fetched into the buffer, never into the cache. Every later miss is compared against the oldest entry (the head) of each buffer. When a head matches, the block is handed to the cache without a demand read. The buffer then shifts up by one entry and queues a fetch for the next block past its tail.

Several buffers work side by side, so interleaved sequential walks each keep their own buffer. A miss that matches no head takes over the buffer that was set up longest ago. The memory port accepts one request at a time. Prefetches use the port only when no demand read is waiting. A head whose data is still on its way is not requested a second time: the miss waits for the data already in flight.

The memory side uses a valid/ready request handshake with one request outstanding. The response is a single-cycle pulse carrying the data of that request. It arrives at least one cycle after the request is accepted.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset, miss_ready is 1, fill_valid is 0 and mem_req_valid is 0.
- R2: A miss whose address matches no buffer head produces a fill for that address. The fill carries the memory data and has fill_from_buf = 0.
- R3: A miss that matches no head loads a buffer with the DEPTH block addresses that follow it. A following miss at the next address is then served with fill_from_buf = 1.
- R4: Only buffer heads are compared. A miss on an address held deeper in a buffer is handled as an unmatched miss (fill_from_buf = 0).
- R5: A head match delivers that block, advances the buffer, and appends the block after the old tail. A sequential walk longer than DEPTH is therefore served from the buffer at every step, with correct data.
- R6: Up to NUM_BUF interleaved sequential streams are each served from their own buffer.
- R7: An unmatched miss replaces the buffer whose allocation is oldest. Streams in the other buffers are still served afterwards.
- R8: While a demand read waits and no request is outstanding, the memory request carries the demand address. That request stays stable until accepted. After an unmatched miss, the next request accepted is the demand for that address.
- R9: A head match on an entry whose data is still outstanding waits for that data. Every block served from a buffer has been requested from memory exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Block can accept a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Block address to read |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | DATA_W | Read data |
| fill_valid | output | 1 | Block returned to the cache (one cycle) |
| fill_addr | output | ADDR_W | Address of the returned block |
| fill_data | output | DATA_W | Data of the returned block |
| fill_from_buf | output | 1 | 1 if served from a stream buffer, 0 if from a demand read |

## Verification
Two events can land in the same cycle. In the first, the memory response for a buffer head arrives in the cycle a miss matches that head. The match must then deliver at once, not wait for data that has already come. In the second, a prefetch is accepted by memory in the cycle a miss is taken in. The miss may even flush the buffer that issued the prefetch. Both are provoked by sweeping memory latency from zero upward against stalling and non-stalling ready patterns, while sequential walks and interleaved streams run. Each case is judged by the fill address, the data, the buffer flag, and a per-address count of memory requests.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        SBP_IDLE   = 2'd0,
        SBP_DEMAND = 2'd1,
        SBP_WAIT   = 2'd2
    } sbp_state_e;

endpackage

// File: rtl/sbp_head_match.sv
module sbp_head_match #(
    parameter int ADDR_W  = 12,
    parameter int NUM_BUF = 4,
    parameter int BW      = 2
) (
    input  logic [NUM_BUF-1:0]        head_vld,
    input  logic [NUM_BUF*ADDR_W-1:0] head_addr,
    input  logic [ADDR_W-1:0]         probe_addr,
    output logic                      hit,
    output logic [BW-1:0]             hit_idx
);

    logic [NUM_BUF-1:0] eq;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_cmp
        assign eq[g] = head_vld[g] && (head_addr[g*ADDR_W +: ADDR_W] == probe_addr);
    end

    // lowest-numbered matching buffer wins
    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = BW'(i);
        end
    end

endmodule

// File: rtl/sbp_pf_pick.sv
module sbp_pf_pick #(
    parameter int NE = 16,
    parameter int IW = 4
) (
    input  logic [NE-1:0] need,
    output logic          found,
    output logic [IW-1:0] idx
);

    // lowest flat index (buffer-major, head first) gets the port
    always_comb begin
        found = |need;
        idx   = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (need[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
    import sbp_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_BUF = 4,
    parameter int DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_from_buf
);

    localparam int BW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NE = NUM_BUF * DEPTH;
    localparam int IW = (NE > 1) ? $clog2(NE) : 1;

    typedef struct packed {
        logic              vld;
        logic              pend;
        logic              iss;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ent_t;

    typedef ent_t [DEPTH-1:0] row_t;

    typedef struct packed {
        row_t [NUM_BUF-1:0] rows;
        sbp_state_e         st;
        logic               dem_iss;
        logic [ADDR_W-1:0]  dem_addr;
        logic [BW-1:0]      wait_buf;
        logic               out_vld;
        logic               out_dem;
        logic [BW-1:0]      out_buf;
        logic [ADDR_W-1:0]  out_addr;
        logic [BW-1:0]      alloc_ptr;
        logic               fill_vld;
        logic [ADDR_W-1:0]  fill_addr;
        logic [DATA_W-1:0]  fill_data;
        logic               fill_buf;
    } regs_t;

    regs_t q, n;

    // advance a buffer by one and append the block after its old tail
    function automatic row_t shift_in(row_t r);
        row_t o;
        for (int s = 0; s < DEPTH - 1; s++) o[s] = r[s + 1];
        o[DEPTH-1] = '{vld: 1'b1, pend: 1'b1, iss: 1'b0,
                       addr: r[DEPTH-1].addr + ADDR_W'(1), data: '0};
        return o;
    endfunction

    // restart a buffer at the blocks that follow a miss
    function automatic row_t fresh_row(logic [ADDR_W-1:0] a);
        row_t o;
        for (int s = 0; s < DEPTH; s++) begin
            o[s] = '{vld: 1'b1, pend: 1'b1, iss: 1'b0,
                     addr: a + ADDR_W'(s + 1), data: '0};
        end
        return o;
    endfunction

    logic [NUM_BUF-1:0]        head_vld;
    logic [NUM_BUF*ADDR_W-1:0] head_addr;
    logic [NE-1:0]             pf_need;
    logic                      hm_hit;
    logic [BW-1:0]             hm_idx;
    logic                      pf_found;
    logic [IW-1:0]             pf_idx;
    logic [BW-1:0]             pf_b;
    logic [SW-1:0]             pf_s;

    always_comb begin
        for (int b = 0; b < NUM_BUF; b++) begin
            head_vld[b]                   = q.rows[b][0].vld;
            head_addr[b*ADDR_W +: ADDR_W] = q.rows[b][0].addr;
            for (int s = 0; s < DEPTH; s++) begin
                pf_need[b*DEPTH + s] = q.rows[b][s].vld && !q.rows[b][s].iss;
            end
        end
    end

    sbp_head_match #(.ADDR_W(ADDR_W), .NUM_BUF(NUM_BUF), .BW(BW)) u_match (
        .head_vld  (head_vld),
        .head_addr (head_addr),
        .probe_addr(miss_addr),
        .hit       (hm_hit),
        .hit_idx   (hm_idx)
    );

    sbp_pf_pick #(.NE(NE), .IW(IW)) u_pick (
        .need (pf_need),
        .found(pf_found),
        .idx  (pf_idx)
    );

    always_comb begin
        pf_b = BW'(32'(pf_idx) / DEPTH);
        pf_s = SW'(32'(pf_idx) % DEPTH);
    end

    // demand always outranks prefetch; one request in flight at a time
    assign mem_req_valid = !q.out_vld && (q.dem_iss || pf_found);
    assign mem_req_addr  = q.dem_iss ? q.dem_addr : q.rows[pf_b][pf_s].addr;
    assign miss_ready    = (q.st == SBP_IDLE);
    assign fill_valid    = q.fill_vld;
    assign fill_addr     = q.fill_addr;
    assign fill_data     = q.fill_data;
    assign fill_from_buf = q.fill_buf;

    always_comb begin
        logic          pop_go;
        logic [BW-1:0] pop_idx;
        n          = q;
        n.fill_vld = 1'b0;
        pop_go     = 1'b0;
        pop_idx    = '0;

        // 1) a response lands in the buffer entry it was issued for
        if (mem_rsp_valid && q.out_vld) begin
            n.out_vld = 1'b0;
            if (!q.out_dem) begin
                for (int s = 0; s < DEPTH; s++) begin
                    if (n.rows[q.out_buf][s].vld && n.rows[q.out_buf][s].pend &&
                        n.rows[q.out_buf][s].iss && n.rows[q.out_buf][s].addr == q.out_addr) begin
                        n.rows[q.out_buf][s].data = mem_rsp_data;
                        n.rows[q.out_buf][s].pend = 1'b0;
                    end
                end
            end
        end

        // 2) request accepted by memory
        if (mem_req_valid && mem_req_ready) begin
            n.out_vld  = 1'b1;
            n.out_addr = mem_req_addr;
            n.out_dem  = q.dem_iss;
            n.out_buf  = pf_b;
            if (q.dem_iss) n.dem_iss = 1'b0;
            else           n.rows[pf_b][pf_s].iss = 1'b1;
        end

        // 3) miss handling
        case (q.st)
            SBP_IDLE: begin
                if (miss_valid) begin
                    if (hm_hit) begin
                        if (n.rows[hm_idx][0].pend) begin
                            n.st       = SBP_WAIT;
                            n.wait_buf = hm_idx;
                        end else begin
                            pop_go  = 1'b1;
                            pop_idx = hm_idx;
                        end
                    end else begin
                        n.rows[q.alloc_ptr] = fresh_row(miss_addr);
                        n.alloc_ptr = (q.alloc_ptr == BW'(NUM_BUF - 1)) ? '0 : q.alloc_ptr + 1'b1;
                        n.st        = SBP_DEMAND;
                        n.dem_iss   = 1'b1;
                        n.dem_addr  = miss_addr;
                    end
                end
            end
            SBP_WAIT: begin
                if (!n.rows[q.wait_buf][0].pend) begin
                    pop_go  = 1'b1;
                    pop_idx = q.wait_buf;
                    n.st    = SBP_IDLE;
                end
            end
            SBP_DEMAND: begin
                if (mem_rsp_valid && q.out_vld && q.out_dem) begin
                    n.fill_vld  = 1'b1;
                    n.fill_addr = q.out_addr;
                    n.fill_data = mem_rsp_data;
                    n.fill_buf  = 1'b0;
                    n.st        = SBP_IDLE;
                end
            end
            default: n.st = SBP_IDLE;
        endcase

        if (pop_go) begin
            n.fill_vld      = 1'b1;
            n.fill_addr     = n.rows[pop_idx][0].addr;
            n.fill_data     = n.rows[pop_idx][0].data;
            n.fill_buf      = 1'b1;
            n.rows[pop_idx] = shift_in(n.rows[pop_idx]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    AST_DEMAND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dem_iss && !q.out_vld) |-> (mem_req_valid && mem_req_addr == q.dem_addr)); // R8
    AST_DEMAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && q.dem_iss) |=> (mem_req_valid && $stable(mem_req_addr))); // R8
    AST_FILL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> ($past(miss_valid && miss_ready) || $past(q.st != SBP_IDLE))); // R2
    AST_WAIT_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SBP_WAIT) |-> q.rows[q.wait_buf][0].pend); // R9

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_chk
        AST_FULL_OR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            q.rows[b][0].vld == q.rows[b][DEPTH-1].vld); // R3
        AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            q.rows[b][0].vld |-> (q.rows[b][1].addr == q.rows[b][0].addr + ADDR_W'(1))); // R5
    end

endmodule

// File: tb/tb_stream_prefetcher.sv
`timescale 1ns/1ps
module tb_stream_prefetcher;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NB = 4;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic          miss_ready;
    logic [AW-1:0] miss_addr = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic          fill_from_buf;

    stream_prefetcher #(.ADDR_W(AW), .DATA_W(DW), .NUM_BUF(NB), .DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_from_buf(fill_from_buf)
    );

    always #10 clk = ~clk;

    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    int          lat    = 0;
    int          rdy_mod = 0;
    bit          busy   = 1'b0;
    int          lat_cnt = 0;
    logic [AW-1:0] cur_a = '0;
    bit          dem_arm = 1'b0;
    logic [AW-1:0] dem_exp = '0;
    int unsigned req_cnt [4096];

    function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
        return 32'(a) * 32'h0001_0003 + 32'h5A5A;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one cycle: sample and drive at the falling edge, with a memory model
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (busy) begin
            if (lat_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_val(cur_a);
                busy          = 1'b0;
            end else begin
                lat_cnt--;
            end
        end
        mem_req_ready = (rdy_mod == 0) || (cyc % rdy_mod != 0);
        if (!busy && mem_req_valid && mem_req_ready) begin
            busy    = 1'b1;
            cur_a   = mem_req_addr;
            lat_cnt = lat;
            req_cnt[mem_req_addr]++;
            if (dem_arm) begin
                check(mem_req_addr == dem_exp, "R8", "first request after unmatched miss",
                      mem_req_addr, dem_exp);
                dem_arm = 1'b0;
            end
        end
    endtask

    task automatic do_miss(logic [AW-1:0] a, string tag, bit exp_hit);
        bit got = 1'b0;
        int t = 0;
        dem_arm = 1'b0;
        while (!miss_ready && t < 400) begin
            tick();
            t++;
        end
        miss_valid = 1'b1;
        miss_addr  = a;
        if (!exp_hit) begin
            dem_arm = 1'b1;
            dem_exp = a;
        end
        tick();
        miss_valid = 1'b0;
        for (int k = 0; k < 400 && !got; k++) begin
            if (fill_valid) got = 1'b1;
            else            tick();
        end
        check(got, tag, "fill arrives", got, 1);
        if (got) begin
            check(fill_addr == a, tag, "fill_addr", fill_addr, a);
            check(fill_data == mem_val(a), tag, "fill_data", fill_data, mem_val(a));
            check(fill_from_buf == exp_hit, tag, "fill_from_buf", fill_from_buf, exp_hit);
            if (exp_hit)
                check(req_cnt[a] == 1, "R9", "memory requests for served block", req_cnt[a], 1);
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) req_cnt[i] = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: idle after reset
        check(miss_ready == 1'b1, "R1", "miss_ready", miss_ready, 1);
        check(fill_valid == 1'b0, "R1", "fill_valid", fill_valid, 0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);

        for (int cfg = 0; cfg < 8; cfg++) begin
            logic [AW-1:0] base;
            logic [AW-1:0] s [NB];
            case (cfg % 4)
                0: lat = 0;
                1: lat = 1;
                2: lat = 3;
                default: lat = 6;
            endcase
            rdy_mod = (cfg < 4) ? 0 : 3;
            base = AW'(cfg * 256 + 16);

            // R2, R3: unmatched miss then sequential walk
            do_miss(base, "R2", 1'b0);
            do_miss(base + AW'(1), "R3", 1'b1);
            for (int k = 2; k <= 10; k++) do_miss(base + AW'(k), "R5", 1'b1);

            // R4: an address deeper in a buffer does not match
            do_miss(base + AW'(64), "R2", 1'b0);
            do_miss(base + AW'(66), "R4", 1'b0);

            // R6: interleaved streams
            for (int i = 0; i < NB; i++) begin
                s[i] = base + AW'(96 + 16 * i);
                do_miss(s[i], "R2", 1'b0);
            end
            for (int r = 1; r <= 3; r++)
                for (int i = 0; i < NB; i++)
                    do_miss(s[i] + AW'(r), "R6", 1'b1);

            // R7: oldest allocation is replaced, the others survive
            do_miss(base + AW'(176), "R7", 1'b0);
            do_miss(s[0] + AW'(4), "R7", 1'b0);
            do_miss(s[2] + AW'(4), "R7", 1'b1);
            do_miss(s[3] + AW'(4), "R7", 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule